// File: doc/BRIEF.md
# Break return address selector

When a user break is taken, this block works out which program-counter value goes onto the stack. It watches the stream of issued instructions. For each instruction it sees the address, the next sequential address, the branch destination, and two tags: one says the instruction is a delayed branch, the other says it sits in a delay slot. Alongside the stream it gets a break-match pulse and the timing mode of the break condition. The mode is either a fetch checked before execution or a fetch checked after execution.

The block keeps a record of the most recent delayed branch, both its own address and its destination. This lets a match on the delay-slot instruction that follows fall back to that branch. One cycle after a qualified match, the block raises a strobe for exactly one cycle. With the strobe it presents three results: the address to save, a flag that says whether the matched instruction may complete before the break, and a flag that says whether the break position is exact. The break position counts as exact only when the condition was set on the instruction-side bus and carries no data qualifier.

Pushing the value onto the stack, exception entry and instruction decoding are left to the surrounding logic.

Top module: `brk_ret_sel`

## Requirements
- R1: Reset is synchronous and active high. During and after reset, `take`, `save_addr`, `exec_ok` and `precise` are 0, and the branch record (address and destination) is cleared to 0.
- R2: In before-execution mode (`brk_mode`=0), a match on an instruction that is not a delay slot saves that instruction's own address and drives `exec_ok`=0. This holds for a delayed branch too.
- R3: In before-execution mode, a match on a delay-slot instruction (`insn_slot`=1) saves the address of the recorded delayed branch, with `exec_ok`=0.
- R4: In after-execution mode (`brk_mode`=1), a match on an instruction that is neither a delayed branch nor a delay slot saves `insn_next`, with `exec_ok`=1.
- R5: In after-execution mode, a match on a delayed branch (`insn_dbr`=1) saves that instruction's `insn_target`, with `exec_ok`=1.
- R6: In after-execution mode, a match on a delay-slot instruction saves the recorded branch destination, with `exec_ok`=1.
- R7: `take` is 1 in the cycle after a cycle with `insn_valid`=1 and `brk_hit`=1, and 0 otherwise. While `take`=0, `save_addr`, `exec_ok` and `precise` are 0.
- R8: With `take`=1, `precise` is 1 exactly when the match cycle had `cond_ibus`=1 and `cond_data`=0.
- R9: The branch record loads `insn_addr` and `insn_target` only in a cycle with `insn_valid`=1 and `insn_dbr`=1. Other instructions leave it unchanged.
- R10: `brk_hit` while `insn_valid`=0 is ignored. It causes no strobe and does not change the branch record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| insn_valid | input | 1 | An instruction is presented this cycle |
| insn_addr | input | AW | Address of the presented instruction |
| insn_next | input | AW | Next sequential address |
| insn_target | input | AW | Branch destination of the presented instruction |
| insn_dbr | input | 1 | Presented instruction is a delayed branch |
| insn_slot | input | 1 | Presented instruction is in a delay slot |
| brk_hit | input | 1 | Break condition matched this instruction |
| brk_mode | input | 1 | 0 = checked before execution, 1 = after execution |
| cond_ibus | input | 1 | Condition is on the instruction-side bus |
| cond_data | input | 1 | Condition includes a data qualifier |
| take | output | 1 | One-cycle break strobe |
| save_addr | output | AW | Address to push on the stack |
| exec_ok | output | 1 | Matched instruction completes before the break |
| precise | output | 1 | Break position is exact |

## Verification
The bench builds the block with `AW`=16. This keeps the vector table readable and lets every address field be checked as a whole word, while all selection paths still have the same structure as at the default width. Its table runs through breaks and branches in sequence, so the record left by one delayed branch is consumed by later delay-slot matches in both modes. It then checks that a plain instruction between a branch and a slot match leaves the record alone. Directed steps cover a slot match right after reset (record at zero), matches without a valid instruction, and all four combinations of bus selection and data qualifier.

// File: rtl/brk_pkg.sv
package brk_pkg;
  typedef enum logic {
    MODE_PRE  = 1'b0,
    MODE_POST = 1'b1
  } brk_mode_e;
endpackage

// File: rtl/brk_branch_rec.sv
module brk_branch_rec #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          upd,
  input  logic [AW-1:0] br_addr,
  input  logic [AW-1:0] br_tgt,
  output logic [AW-1:0] rec_addr,
  output logic [AW-1:0] rec_tgt
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rec_addr <= '0;
      rec_tgt  <= '0;
    end else if (upd) begin
      rec_addr <= br_addr;
      rec_tgt  <= br_tgt;
    end
  end
endmodule

// File: rtl/brk_addr_pick.sv
module brk_addr_pick
  import brk_pkg::*;
#(
  parameter int AW = 32
) (
  input  brk_mode_e     mode,
  input  logic          is_dbr,
  input  logic          is_slot,
  input  logic [AW-1:0] ins_addr,
  input  logic [AW-1:0] ins_next,
  input  logic [AW-1:0] ins_tgt,
  input  logic [AW-1:0] rec_addr,
  input  logic [AW-1:0] rec_tgt,
  output logic [AW-1:0] pick_addr,
  output logic          pick_exec
);
  always_comb begin
    if (mode == MODE_PRE) begin
      pick_exec = 1'b0;
      pick_addr = is_slot ? rec_addr : ins_addr;
    end else begin
      pick_exec = 1'b1;
      if (is_slot)     pick_addr = rec_tgt;
      else if (is_dbr) pick_addr = ins_tgt;
      else             pick_addr = ins_next;
    end
  end
endmodule

// File: rtl/brk_ret_sel.sv
module brk_ret_sel
  import brk_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          insn_valid,
  input  logic [AW-1:0] insn_addr,
  input  logic [AW-1:0] insn_next,
  input  logic [AW-1:0] insn_target,
  input  logic          insn_dbr,
  input  logic          insn_slot,
  input  logic          brk_hit,
  input  logic          brk_mode,
  input  logic          cond_ibus,
  input  logic          cond_data,
  output logic          take,
  output logic [AW-1:0] save_addr,
  output logic          exec_ok,
  output logic          precise
);
  logic [AW-1:0] rec_addr, rec_tgt, pick_addr;
  logic          pick_exec;
  logic          hit_q;

  assign hit_q = insn_valid & brk_hit;

  brk_branch_rec #(.AW(AW)) u_rec (
    .clk      (clk),
    .rst      (rst),
    .upd      (insn_valid & insn_dbr),
    .br_addr  (insn_addr),
    .br_tgt   (insn_target),
    .rec_addr (rec_addr),
    .rec_tgt  (rec_tgt)
  );

  brk_addr_pick #(.AW(AW)) u_pick (
    .mode      (brk_mode_e'(brk_mode)),
    .is_dbr    (insn_dbr),
    .is_slot   (insn_slot),
    .ins_addr  (insn_addr),
    .ins_next  (insn_next),
    .ins_tgt   (insn_target),
    .rec_addr  (rec_addr),
    .rec_tgt   (rec_tgt),
    .pick_addr (pick_addr),
    .pick_exec (pick_exec)
  );

  always_ff @(posedge clk) begin
    if (rst || !hit_q) begin
      take      <= 1'b0;
      save_addr <= '0;
      exec_ok   <= 1'b0;
      precise   <= 1'b0;
    end else begin
      take      <= 1'b1;
      save_addr <= pick_addr;
      exec_ok   <= pick_exec;
      precise   <= cond_ibus & ~cond_data;
    end
  end
endmodule

// File: rtl/brk_ret_sel_chk.sv
module brk_ret_sel_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          insn_valid,
  input logic [AW-1:0] insn_addr,
  input logic [AW-1:0] insn_next,
  input logic [AW-1:0] insn_target,
  input logic          insn_dbr,
  input logic          insn_slot,
  input logic          brk_hit,
  input logic          brk_mode,
  input logic          cond_ibus,
  input logic          cond_data,
  input logic          take,
  input logic [AW-1:0] save_addr,
  input logic          exec_ok,
  input logic          precise
);
  assert_strobe_on_hit_R7: assert property (@(posedge clk) disable iff (rst)
    (insn_valid && brk_hit) |=> take);
  assert_no_strobe_R10: assert property (@(posedge clk) disable iff (rst)
    !(insn_valid && brk_hit) |=> !take);
  assert_idle_zero_R7: assert property (@(posedge clk) disable iff (rst)
    !take |-> (save_addr == '0 && !exec_ok && !precise));
  assert_pre_own_addr_R2: assert property (@(posedge clk) disable iff (rst)
    (insn_valid && brk_hit && !brk_mode && !insn_slot) |=>
      (save_addr == $past(insn_addr) && !exec_ok));
  assert_post_next_R4: assert property (@(posedge clk) disable iff (rst)
    (insn_valid && brk_hit && brk_mode && !insn_slot && !insn_dbr) |=>
      (save_addr == $past(insn_next) && exec_ok));
  assert_post_target_R5: assert property (@(posedge clk) disable iff (rst)
    (insn_valid && brk_hit && brk_mode && !insn_slot && insn_dbr) |=>
      (save_addr == $past(insn_target) && exec_ok));
  assert_precise_R8: assert property (@(posedge clk) disable iff (rst)
    (insn_valid && brk_hit) |=> (precise == $past(cond_ibus && !cond_data)));
endmodule

bind brk_ret_sel brk_ret_sel_chk #(.AW(AW)) u_chk (.*);

// File: tb/brk_ret_sel_test.sv
module brk_ret_sel_test;
  localparam int AW = 16;

  typedef struct packed {
    logic          mode;
    logic          hit;
    logic          dbr;
    logic          slot;
    logic [AW-1:0] addr;
    logic [AW-1:0] nxt;
    logic [AW-1:0] tgt;
    logic          e_take;
    logic [AW-1:0] e_addr;
    logic          e_exec;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VEC [NV] = '{
    '{1'b0,1'b1,1'b0,1'b0,16'h0100,16'h0102,16'h0000,1'b1,16'h0100,1'b0}, // R2
    '{1'b1,1'b1,1'b0,1'b0,16'h0104,16'h0106,16'h0000,1'b1,16'h0106,1'b1}, // R4
    '{1'b0,1'b0,1'b1,1'b0,16'h0200,16'h0202,16'h0300,1'b0,16'h0000,1'b0}, // R9 load
    '{1'b0,1'b1,1'b0,1'b1,16'h0202,16'h0204,16'h0000,1'b1,16'h0200,1'b0}, // R3
    '{1'b1,1'b1,1'b1,1'b0,16'h0210,16'h0212,16'h0400,1'b1,16'h0400,1'b1}, // R5
    '{1'b1,1'b1,1'b0,1'b1,16'h0212,16'h0214,16'h0000,1'b1,16'h0400,1'b1}, // R6
    '{1'b0,1'b0,1'b0,1'b0,16'h0220,16'h0222,16'h0999,1'b0,16'h0000,1'b0}, // R7 idle
    '{1'b0,1'b1,1'b0,1'b1,16'h0222,16'h0224,16'h0000,1'b1,16'h0210,1'b0}, // R9 kept
    '{1'b0,1'b1,1'b1,1'b0,16'h0230,16'h0232,16'h0500,1'b1,16'h0230,1'b0}, // R2 dbr
    '{1'b1,1'b1,1'b0,1'b1,16'h0232,16'h0234,16'h0000,1'b1,16'h0500,1'b1}  // R6
  };

  logic          clk = 1'b0;
  logic          rst;
  logic          insn_valid, insn_dbr, insn_slot, brk_hit, brk_mode;
  logic          cond_ibus, cond_data;
  logic [AW-1:0] insn_addr, insn_next, insn_target;
  logic          take, exec_ok, precise;
  logic [AW-1:0] save_addr;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;

  always #5 clk = ~clk;

  brk_ret_sel #(.AW(AW)) uut (
    .clk(clk), .rst(rst), .insn_valid(insn_valid), .insn_addr(insn_addr),
    .insn_next(insn_next), .insn_target(insn_target), .insn_dbr(insn_dbr),
    .insn_slot(insn_slot), .brk_hit(brk_hit), .brk_mode(brk_mode),
    .cond_ibus(cond_ibus), .cond_data(cond_data), .take(take),
    .save_addr(save_addr), .exec_ok(exec_ok), .precise(precise)
  );

  task automatic chk(input string req, input logic [AW-1:0] got, input logic [AW-1:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic drive(input logic v, input logic hit, input logic mode, input logic dbr,
                       input logic slot, input logic [AW-1:0] a, input logic [AW-1:0] n,
                       input logic [AW-1:0] t);
    insn_valid = v; brk_hit = hit; brk_mode = mode; insn_dbr = dbr;
    insn_slot = slot; insn_addr = a; insn_next = n; insn_target = t;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 5000) begin
      bad++;
      $display("FAIL watchdog: got %0d expected below 5000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    cond_ibus = 1'b1; cond_data = 1'b0;
    drive(1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 16'h0AAA, 16'h0AAC, 16'h0BBB);
    repeat (3) @(negedge clk);
    chk("R1 take", {15'd0, take}, 16'd0);
    chk("R1 addr", save_addr, 16'd0);
    chk("R1 flags", {14'd0, exec_ok, precise}, 16'd0);
    rst = 1'b0;
    // R1: branch record is zero after reset
    drive(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 16'h0010, 16'h0012, 16'h0000);
    @(negedge clk);
    chk("R1 record", save_addr, 16'h0000);
    chk("R1 record take", {15'd0, take}, 16'd1);

    for (int i = 0; i < NV; i++) begin
      drive(1'b1, VEC[i].hit, VEC[i].mode, VEC[i].dbr, VEC[i].slot,
            VEC[i].addr, VEC[i].nxt, VEC[i].tgt);
      @(negedge clk);
      chk($sformatf("R7 row%0d take", i), {15'd0, take}, {15'd0, VEC[i].e_take});
      chk($sformatf("R2-6 row%0d addr", i), save_addr, VEC[i].e_addr);
      chk($sformatf("R2-6 row%0d exec", i), {15'd0, exec_ok}, {15'd0, VEC[i].e_exec});
    end

    // R7: strobe lasts one cycle
    drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0, 16'h0, 16'h0);
    @(negedge clk);
    chk("R7 one cycle", {15'd0, take}, 16'd0);

    // R10: hit without valid ignored, record untouched
    drive(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 16'h0F00, 16'h0F02, 16'h0F80);
    @(negedge clk);
    chk("R10 no take", {15'd0, take}, 16'd0);
    chk("R10 addr zero", save_addr, 16'd0);
    drive(1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 16'h0236, 16'h0238, 16'h0000);
    @(negedge clk);
    chk("R10 record kept", save_addr, 16'h0500);

    // R8: all bus/qualifier combinations
    for (int k = 0; k < 4; k++) begin
      cond_ibus = k[0]; cond_data = k[1];
      drive(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0300, 16'h0302, 16'h0);
      @(negedge clk);
      chk($sformatf("R8 combo%0d", k), {15'd0, precise},
          {15'd0, (k == 1) ? 1'b1 : 1'b0});
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule